// File: doc/BRIEF.md
# Dual-Alias General Register File

This block holds the integer register state of a 64-bit processor core: thirty-one general registers (numbered 0 to 30) and one stack-pointer register. Operand index 31 has no storage of its own. Each access carries a qualifier bit that decides what index 31 means for that access. When the bit is set, index 31 is the stack pointer. When the bit is clear, index 31 is a zero register: reads of it return zero and writes to it are discarded.

The file has two independent read ports and one write port. Every port has an access size: 8, 16, 32 or 64 bits. A read returns the low field of the register, extended to 64 bits with either sign or zero extension. A narrower write stores the low field and clears every bit above it. A separate link port lets a branch-with-link instruction save its return address into register 30 in the same cycle as any other write.

Reads are combinational. Writes take effect at the rising clock edge.

Top module: `gpr_alias_file`

## Requirements
- R1: With the alias qualifier set, index 31 selects the stack pointer. A read returns its value, and a write updates it at the next rising edge.
- R2: With the alias qualifier clear, a read of index 31 returns zero. A write to index 31 is dropped, and the stack pointer keeps its value.
- R3: A 64-bit write (size code 3) to index 0 to 30 stores all 64 bits. The new value can be read from the cycle after the edge.
- R4: A write of size code 0, 1 or 2 (8, 16 or 32 bits) stores the low 8, 16 or 32 bits of the write data and clears all higher bits to zero.
- R5: The read size code selects the returned field: 0 gives bits 7:0, 1 gives bits 15:0, 2 gives bits 31:0 and 3 gives all 64 bits. With the extend flag at 1, a narrow field is sign-extended. With the flag at 0, it is zero-extended. For size 3 the flag has no effect.
- R6: When the link enable is high at a rising edge, the link address is stored into register 30.
- R7: If the link enable and a normal write to register 30 occur in the same cycle, register 30 takes the link address.
- R8: In a cycle where a register is being written, reads of that register return its old value. There is no write-to-read bypass.
- R9: A synchronous active-high reset clears all thirty-one registers and the stack pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_sp | input | 1 | Read port A: index 31 means stack pointer |
| rd_a_size | input | 2 | Read port A size code (0=8, 1=16, 2=32, 3=64 bits) |
| rd_a_sext | input | 1 | Read port A: sign-extend the narrow field |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_sp | input | 1 | Read port B: index 31 means stack pointer |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_sext | input | 1 | Read port B: sign-extend the narrow field |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_sp | input | 1 | Write: index 31 means stack pointer |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data |
| link_en | input | 1 | Save the return address into register 30 |
| link_addr | input | 64 | Return address for the link save |

## Verification
The bench goes after the two meanings of index 31. A design that mixed them up would leak the stack pointer through the zero alias, or would let a write to the discarded alias overwrite the stack pointer. It also checks that narrow writes clear the upper bits. A design that merged the new field into the old value would leave stale high bits that only a full-width read reveals. Other targets are the sign-extension boundary of each field width, a link save colliding with a normal write to register 30, and a read of a register in the same cycle it is written. A design with a bypass would show the new value one cycle early.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        ACC_B = 2'd0,
        ACC_H = 2'd1,
        ACC_W = 2'd2,
        ACC_D = 2'd3
    } acc_size_e;
endpackage

// File: rtl/gpr_read_lane.sv
module gpr_read_lane #(
    parameter int XLEN = 64,
    parameter int IDXW = 5,
    parameter int NREG = 31
) (
    input  logic [NREG-1:0][XLEN-1:0] regs,
    input  logic [XLEN-1:0]           sp_val,
    input  logic [IDXW-1:0]           idx,
    input  logic                      sp_alias,
    input  logic [1:0]                size,
    input  logic                      sext,
    output logic [XLEN-1:0]           data
);
    import gpr_pkg::*;
    localparam int ZIDX = (1 << IDXW) - 1;

    logic [XLEN-1:0] raw;

    always_comb begin
        if (idx == IDXW'(ZIDX)) begin
            raw = sp_alias ? sp_val : '0;
        end else begin
            raw = regs[idx];
        end
    end

    always_comb begin
        case (acc_size_e'(size))
            ACC_B:   data = sext ? {{(XLEN-8){raw[7]}}, raw[7:0]}
                                 : {{(XLEN-8){1'b0}}, raw[7:0]};
            ACC_H:   data = sext ? {{(XLEN-16){raw[15]}}, raw[15:0]}
                                 : {{(XLEN-16){1'b0}}, raw[15:0]};
            ACC_W:   data = sext ? {{(XLEN-32){raw[31]}}, raw[31:0]}
                                 : {{(XLEN-32){1'b0}}, raw[31:0]};
            default: data = raw;
        endcase
    end
endmodule

// File: rtl/gpr_write_shape.sv
module gpr_write_shape #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] din,
    input  logic [1:0]      size,
    output logic [XLEN-1:0] dout
);
    import gpr_pkg::*;

    always_comb begin
        case (acc_size_e'(size))
            ACC_B:   dout = {{(XLEN-8){1'b0}}, din[7:0]};
            ACC_H:   dout = {{(XLEN-16){1'b0}}, din[15:0]};
            ACC_W:   dout = {{(XLEN-32){1'b0}}, din[31:0]};
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
    parameter int XLEN     = 64,
    parameter int IDXW     = 5,
    parameter int NREG     = 31,
    parameter int LINK_IDX = 30
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic                      wr_sp,
    input  logic [XLEN-1:0]           wr_val,
    input  logic                      link_en,
    input  logic [XLEN-1:0]           link_addr,
    output logic [NREG-1:0][XLEN-1:0] regs,
    output logic [XLEN-1:0]           sp_val
);
    localparam int ZIDX = (1 << IDXW) - 1;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] gpr;
        logic [XLEN-1:0]           sp;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_idx == IDXW'(ZIDX)) begin
                if (wr_sp) begin
                    st_d.sp = wr_val;
                end
            end else begin
                st_d.gpr[wr_idx] = wr_val;
            end
        end
        // link save is applied last so it overrides a colliding write
        if (link_en) begin
            st_d.gpr[LINK_IDX] = link_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs   = st_q.gpr;
    assign sp_val = st_q.sp;
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file #(
    parameter int XLEN     = 64,
    parameter int IDXW     = 5,
    parameter int LINK_IDX = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_a_idx,
    input  logic            rd_a_sp,
    input  logic [1:0]      rd_a_size,
    input  logic            rd_a_sext,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [IDXW-1:0] rd_b_idx,
    input  logic            rd_b_sp,
    input  logic [1:0]      rd_b_size,
    input  logic            rd_b_sext,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            wr_sp,
    input  logic [1:0]      wr_size,
    input  logic [XLEN-1:0] wr_data,
    input  logic            link_en,
    input  logic [XLEN-1:0] link_addr
);
    localparam int NREG  = (1 << IDXW) - 1;
    localparam int NPORT = 2;

    logic [NREG-1:0][XLEN-1:0] regs;
    logic [XLEN-1:0]           sp_val;
    logic [XLEN-1:0]           wr_shaped;

    logic [NPORT-1:0][IDXW-1:0] p_idx;
    logic [NPORT-1:0]           p_sp;
    logic [NPORT-1:0][1:0]      p_size;
    logic [NPORT-1:0]           p_sext;
    logic [NPORT-1:0][XLEN-1:0] p_data;

    assign p_idx  = {rd_b_idx,  rd_a_idx};
    assign p_sp   = {rd_b_sp,   rd_a_sp};
    assign p_size = {rd_b_size, rd_a_size};
    assign p_sext = {rd_b_sext, rd_a_sext};

    gpr_write_shape #(.XLEN(XLEN)) u_shape (
        .din  (wr_data),
        .size (wr_size),
        .dout (wr_shaped)
    );

    gpr_store #(
        .XLEN(XLEN), .IDXW(IDXW), .NREG(NREG), .LINK_IDX(LINK_IDX)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_sp     (wr_sp),
        .wr_val    (wr_shaped),
        .link_en   (link_en),
        .link_addr (link_addr),
        .regs      (regs),
        .sp_val    (sp_val)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        gpr_read_lane #(.XLEN(XLEN), .IDXW(IDXW), .NREG(NREG)) u_lane (
            .regs     (regs),
            .sp_val   (sp_val),
            .idx      (p_idx[p]),
            .sp_alias (p_sp[p]),
            .size     (p_size[p]),
            .sext     (p_sext[p]),
            .data     (p_data[p])
        );
    end

    assign rd_a_data = p_data[0];
    assign rd_b_data = p_data[1];
endmodule

// File: rtl/gpr_alias_chk.sv
module gpr_alias_chk #(
    parameter int XLEN     = 64,
    parameter int IDXW     = 5,
    parameter int LINK_IDX = 30
) (
    input logic            clk,
    input logic            rst,
    input logic [IDXW-1:0] rd_a_idx,
    input logic            rd_a_sp,
    input logic [1:0]      rd_a_size,
    input logic            rd_a_sext,
    input logic [XLEN-1:0] rd_a_data,
    input logic [IDXW-1:0] rd_b_idx,
    input logic            rd_b_sp,
    input logic [1:0]      rd_b_size,
    input logic            rd_b_sext,
    input logic [XLEN-1:0] rd_b_data,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic            wr_sp,
    input logic [1:0]      wr_size,
    input logic            link_en,
    input logic [XLEN-1:0] link_addr
);
    localparam logic [IDXW-1:0] ZIDX = IDXW'((1 << IDXW) - 1);
    localparam logic [IDXW-1:0] LIDX = IDXW'(LINK_IDX);

    assert_zero_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == ZIDX && !rd_a_sp) |-> rd_a_data == '0);

    assert_sp_kept_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && wr_idx == ZIDX && !wr_sp && rd_b_idx == ZIDX && rd_b_sp)
         && rd_b_idx == ZIDX && rd_b_sp && $stable(rd_b_size) && $stable(rd_b_sext))
        |-> $stable(rd_b_data));

    assert_word_write_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && wr_size == 2'd2 && wr_idx != ZIDX
               && !(link_en && wr_idx == LIDX))
         && rd_a_idx == $past(wr_idx) && rd_a_size == 2'd3)
        |-> rd_a_data[XLEN-1:32] == '0);

    assert_byte_sext_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_a_size == 2'd0 && rd_a_sext) |-> rd_a_data[XLEN-1:8] == {(XLEN-8){rd_a_data[7]}});

    assert_half_zext_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_b_size == 2'd1 && !rd_b_sext) |-> rd_b_data[XLEN-1:16] == '0);

    assert_link_save_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && link_en) && rd_a_idx == LIDX && rd_a_size == 2'd3)
        |-> rd_a_data == $past(link_addr));

    assert_link_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && link_en && wr_en && wr_idx == LIDX)
         && rd_b_idx == LIDX && rd_b_size == 2'd3)
        |-> rd_b_data == $past(link_addr));
endmodule

bind gpr_alias_file gpr_alias_chk #(
    .XLEN(XLEN), .IDXW(IDXW), .LINK_IDX(LINK_IDX)
) u_chk (.*);

// File: tb/sim_gpr_alias_file.sv
`timescale 1ns/1ps
module sim_gpr_alias_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic        rd_a_sp = 0, rd_b_sp = 0, wr_sp = 0;
    logic [1:0]  rd_a_size = 2'd3, rd_b_size = 2'd3, wr_size = 2'd3;
    logic        rd_a_sext = 0, rd_b_sext = 0;
    logic        wr_en = 0, link_en = 0;
    logic [63:0] wr_data = '0, link_addr = '0;
    logic [63:0] rd_a_data, rd_b_data;

    logic [63:0] m_gpr [31];
    logic [63:0] m_sp;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpr_alias_file u0 (.*);

    function automatic logic [63:0] m_read(input logic [4:0] idx, input logic sp,
                                           input logic [1:0] sz, input logic sx);
        logic [63:0] r;
        r = (idx == 5'd31) ? (sp ? m_sp : 64'd0) : m_gpr[idx];
        case (sz)
            2'd0: return sx ? {{56{r[7]}}, r[7:0]}   : {56'd0, r[7:0]};
            2'd1: return sx ? {{48{r[15]}}, r[15:0]} : {48'd0, r[15:0]};
            2'd2: return sx ? {{32{r[31]}}, r[31:0]} : {32'd0, r[31:0]};
            default: return r;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] idx, input logic sp, input logic [1:0] sz);
        if (idx == 5'd31) return sp ? "R1" : "R2";
        if (sz != 2'd3) return "R5";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // inputs are already set; compare, then advance one clock and update the model
    task automatic step(input string tag);
        logic [63:0] v;
        #1;
        check(tag == "" ? tag_of(rd_a_idx, rd_a_sp, rd_a_size) : tag, rd_a_data,
              m_read(rd_a_idx, rd_a_sp, rd_a_size, rd_a_sext));
        check(tag == "" ? tag_of(rd_b_idx, rd_b_sp, rd_b_size) : tag, rd_b_data,
              m_read(rd_b_idx, rd_b_sp, rd_b_size, rd_b_sext));
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 31; i++) m_gpr[i] = '0;
            m_sp = '0;
        end else begin
            case (wr_size)
                2'd0: v = {56'd0, wr_data[7:0]};
                2'd1: v = {48'd0, wr_data[15:0]};
                2'd2: v = {32'd0, wr_data[31:0]};
                default: v = wr_data;
            endcase
            if (wr_en) begin
                if (wr_idx != 5'd31) m_gpr[wr_idx] = v;
                else if (wr_sp) m_sp = v;
            end
            if (link_en) m_gpr[30] = link_addr;
        end
        @(negedge clk);
        wr_en = 0; link_en = 0;
    endtask

    task automatic rd(input logic [4:0] ai, input logic asp, input logic [1:0] asz, input logic asx,
                      input logic [4:0] bi, input logic bsp, input logic [1:0] bsz, input logic bsx);
        rd_a_idx = ai; rd_a_sp = asp; rd_a_size = asz; rd_a_sext = asx;
        rd_b_idx = bi; rd_b_sp = bsp; rd_b_size = bsz; rd_b_sext = bsx;
    endtask

    task automatic wr(input logic [4:0] i, input logic sp, input logic [1:0] sz, input logic [63:0] d);
        wr_en = 1; wr_idx = i; wr_sp = sp; wr_size = sz; wr_data = d;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 31; i++) m_gpr[i] = '0;
        m_sp = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: state after reset
        for (int i = 0; i < 32; i++) begin
            rd(5'(i), 1, 2'd3, 0, 5'(i), 0, 2'd3, 1);
            step("R9");
        end
        // R3: full write, then read back
        wr(5, 0, 2'd3, 64'h8877_6655_4433_2211); rd(5, 0, 2'd3, 0, 0, 0, 2'd3, 0); step("R8");
        rd(5, 0, 2'd3, 0, 5, 0, 2'd3, 1); step("R3");
        // R5: field extraction at each width
        wr(6, 0, 2'd3, 64'h0123_4567_89AB_CDEF); step("R3");
        rd(6, 0, 2'd0, 1, 6, 0, 2'd0, 0); step("R5");
        rd(6, 0, 2'd1, 1, 6, 0, 2'd1, 0); step("R5");
        rd(6, 0, 2'd2, 1, 6, 0, 2'd2, 0); step("R5");
        rd(5, 0, 2'd0, 1, 5, 0, 2'd2, 1); step("R5");
        // R4: narrow writes clear upper bits
        wr(7, 0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF); step("R3");
        wr(7, 0, 2'd2, 64'hDEAD_BEEF_CAFE_F00D); step("R4");
        rd(7, 0, 2'd3, 0, 7, 0, 2'd3, 1); step("R4");
        wr(7, 0, 2'd0, 64'hAAAA_AAAA_AAAA_AAA5); step("R4");
        rd(7, 0, 2'd3, 0, 7, 0, 2'd0, 1); step("R4");
        wr(8, 0, 2'd1, 64'h1234_5678_9ABC_8001); step("R4");
        rd(8, 0, 2'd3, 0, 8, 0, 2'd1, 1); step("R4");
        // R1: stack pointer alias
        wr(31, 1, 2'd3, 64'h0000_7FFF_FFFF_FFF0); rd(31, 1, 2'd3, 0, 31, 0, 2'd3, 0); step("R8");
        rd(31, 1, 2'd3, 0, 31, 1, 2'd2, 1); step("R1");
        // R2: zero alias write discarded, SP unchanged
        wr(31, 0, 2'd3, 64'h5555_5555_5555_5555); rd(31, 1, 2'd3, 0, 31, 1, 2'd3, 0); step("R2");
        rd(31, 1, 2'd3, 0, 31, 0, 2'd3, 1); step("R2");
        // R6: link save
        link_en = 1; link_addr = 64'h0000_0040_0000_1004; rd(30, 0, 2'd3, 0, 30, 0, 2'd3, 0); step("R8");
        rd(30, 0, 2'd3, 0, 30, 1, 2'd2, 0); step("R6");
        // R7: link save beats a normal write to register 30
        link_en = 1; link_addr = 64'h0000_0040_0000_2008;
        wr(30, 0, 2'd3, 64'hBAD0_BAD0_BAD0_BAD0); step("R7");
        rd(30, 0, 2'd3, 0, 30, 0, 2'd3, 1); step("R7");
        // R8: same-cycle read of written register shows old value
        wr(5, 0, 2'd3, 64'hFEED_FACE_0000_0001); rd(5, 0, 2'd3, 0, 5, 0, 2'd0, 1); step("R8");
        rd(5, 0, 2'd3, 0, 5, 0, 2'd0, 1); step("R3");
        // mixed traffic, compared every cycle
        for (int n = 0; n < 3000; n++) begin
            rd(5'($urandom_range(0, 31)), 1'($urandom), 2'($urandom), 1'($urandom),
               5'($urandom_range(0, 31)), 1'($urandom), 2'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) != 0)
                wr(5'($urandom_range(0, 31)), 1'($urandom), 2'($urandom),
                   {$urandom, $urandom});
            if ($urandom_range(0, 7) == 0) begin
                link_en = 1; link_addr = {$urandom, $urandom};
            end
            step("");
        end
        // R9: reset after traffic
        rst = 1; step("");
        rst = 0;
        for (int i = 0; i < 32; i++) begin
            rd(5'(i), 1, 2'd3, 0, 5'(i), 1, 2'd0, 1);
            step("R9");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule